// File: doc/BRIEF.md
# Grouped configuration word loader

This block takes 12-bit words from a narrow configuration bus and turns them into single wide writes toward the storage of a filter datapath. While the active-low load strobe is held low, one word is taken on every rising clock edge. The words are framed in groups of five. The first word of a group names the target, and the next four carry its contents. Once the fourth content word has arrived, the block issues one write. The target is a row across four coefficient banks, a 32-bit round register, or a 32-bit limit register that holds a lower and an upper 16-bit bound.

Loading starts only after a high-to-low transition of the strobe. A strobe that is already low when reset is released therefore loads nothing. Groups may follow each other with no gap while the strobe stays low. Raising the strobe part way through a group drops that group. The block and the storage it writes share one clock.

Top module: `cfg_word_loader`

## Requirements
- R1: A word on `cfg_word` is taken at a rising edge of `clk` only while `load_n` is low. Words presented while `load_n` is high never cause a write.
- R2: Taking words needs a high-to-low transition of `load_n` seen after reset. If `load_n` is already low when reset is released, nothing is loaded until it has gone high and then low again.
- R3: Each group is one address word followed by four data words. The write strobe for the target is high for the single cycle that follows the edge on which the fourth data word was taken, and no earlier.
- R4: Addresses 0x000 to 0x0FF select a coefficient row equal to address bits 7..0. The write carries the first data word in `coef_data[11:0]` (bank 1), the second in [23:12], the third in [35:24] and the fourth in [47:36].
- R5: Addresses 0x800 to 0x80F select round register `reg_idx` = address bits 3..0, with `rnd_we` high. Bits 7..0 of the four data words form `reg_data` from the least significant byte up to the most significant byte.
- R6: Addresses 0xC00 to 0xC0F select limit register `reg_idx` = address bits 3..0, with `lim_we` high. The bytes are packed in the same way as in R5, so the lower bound is `reg_data[15:0]` (low byte first) and the upper bound is `reg_data[31:16]`.
- R7: For round and limit targets, bits 11..8 of the data words have no effect on `reg_data`.
- R8: While `load_n` stays low, the word after the fourth data word of a group is taken as the next address, so groups follow one another every five cycles.
- R9: An address outside the three regions consumes the next four words and produces no write strobe.
- R10: If `load_n` goes high before a group is complete, the partial group is dropped and no write occurs. The next armed load starts again with an address word.
- R11: After reset all write strobes are low and all data, row and index outputs are zero. At most one strobe is high in any cycle, and each write lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the configuration bus and the storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low load strobe |
| cfg_word | input | 12 | Configuration word (address or data) |
| coef_we | output | 1 | Coefficient row write strobe |
| coef_row | output | 8 | Coefficient row being written |
| coef_data | output | 48 | Four bank values, bank 1 in the low 12 bits |
| rnd_we | output | 1 | Round register write strobe |
| lim_we | output | 1 | Limit register write strobe |
| reg_idx | output | 4 | Round or limit register index |
| reg_data | output | 32 | Round value, or upper bound and lower bound |

## Verification
A wrong phase count shows up at the ports within one group, about five cycles. The strobe arrives early or late, data words end up in the wrong bank or byte lane, or an address word is taken as data, which sends the following group to the wrong place. A wrong arming state shows up as a write during the reset-low window, or as a dropped first group after a proper falling edge. The bench runs every one of the 4096 address values back to back. It compares each strobe, index and data word with values it computes from the address. It also counts every write pulse, which exposes stray or missing strobes between groups.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Destination class of one group, decoded from its address word
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_COEF = 2'd1,
    TGT_RND  = 2'd2,
    TGT_LIM  = 2'd3
  } tgt_e;

endpackage

// File: rtl/cfg_load_arm.sv
module cfg_load_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic take
);

  logic strobe_q, strobe_d;
  logic armed_q, armed_d;

  // armed stays set while the strobe is low, and sets only when the
  // strobe was seen high on the previous edge
  always_comb begin
    strobe_d = load_n;
    armed_d  = ~load_n & (armed_q | strobe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      armed_q  <= armed_d;
    end
  end

  assign take = armed_d;

  AST_ARM_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(load_n, 2)); // R2

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_loader_pkg::*;
#(
  parameter int                CFG_W    = 12,
  parameter int                ROW_AW   = 8,
  parameter int                IDX_W    = 4,
  parameter logic [CFG_W-1:0]  RND_BASE = 'h800,
  parameter logic [CFG_W-1:0]  LIM_BASE = 'hC00
) (
  input  logic [CFG_W-1:0]  addr,
  output tgt_e              tgt,
  output logic [ROW_AW-1:0] row,
  output logic [IDX_W-1:0]  idx
);

  localparam int TAG_W = CFG_W - IDX_W;

  logic [TAG_W-1:0] tag;

  always_comb begin
    tag = addr[CFG_W-1:IDX_W];
    row = addr[ROW_AW-1:0];
    idx = addr[IDX_W-1:0];
    if (addr[CFG_W-1:ROW_AW] == '0) begin
      tgt = TGT_COEF;
    end else if (tag == RND_BASE[CFG_W-1:IDX_W]) begin
      tgt = TGT_RND;
    end else if (tag == LIM_BASE[CFG_W-1:IDX_W]) begin
      tgt = TGT_LIM;
    end else begin
      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/cfg_word_gather.sv
module cfg_word_gather #(
  parameter int CFG_W    = 12,
  parameter int NUM_DATA = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            take,
  input  logic [CFG_W-1:0]                word,
  output logic [CFG_W-1:0]                addr_q,
  output logic [(NUM_DATA-1)*CFG_W-1:0]   slots_flat,
  output logic                            last_now
);

  localparam int              PH_W = $clog2(NUM_DATA + 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_DATA);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [CFG_W-1:0] addr_d;
  logic             addr_en;

  // phase 0 expects an address, phases 1..NUM_DATA expect data words
  always_comb begin
    addr_en  = take && (phase_q == '0);
    addr_d   = word;
    last_now = take && (phase_q == LAST);
    if (!take || phase_q == LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // the last data word is never stored: it goes straight to the commit stage
  for (genvar k = 0; k < NUM_DATA - 1; k++) begin : g_slot
    logic [CFG_W-1:0] slot_q;
    logic             slot_en;

    always_comb slot_en = take && (phase_q == PH_W'(k + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= word;
      end
    end

    assign slots_flat[k*CFG_W +: CFG_W] = slot_q;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R3
  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && phase_q != LAST) |=> (phase_q == PH_W'($past(phase_q) + 1'b1))); // R3
  AST_GROUP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    last_now |=> (phase_q == '0)); // R8
  AST_ABANDON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (phase_q == '0)); // R10

endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfg_loader_pkg::*;
#(
  parameter int CFG_W    = 12,
  parameter int NUM_DATA = 4,
  parameter int ROW_AW   = 8,
  parameter int IDX_W    = 4,
  parameter int BYTE_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  tgt_e                         tgt,
  input  logic [ROW_AW-1:0]            row,
  input  logic [IDX_W-1:0]             idx,
  input  logic [NUM_DATA*CFG_W-1:0]    words_flat,
  output logic                         coef_we,
  output logic [ROW_AW-1:0]            coef_row,
  output logic [NUM_DATA*CFG_W-1:0]    coef_data,
  output logic                         rnd_we,
  output logic                         lim_we,
  output logic [IDX_W-1:0]             reg_idx,
  output logic [NUM_DATA*BYTE_W-1:0]   reg_data
);

  localparam int REG_W  = NUM_DATA * BYTE_W;
  localparam int COEF_W = NUM_DATA * CFG_W;

  logic [REG_W-1:0] packed_bytes;

  // low byte of each word, first word in the least significant lane
  for (genvar k = 0; k < NUM_DATA; k++) begin : g_lane
    assign packed_bytes[k*BYTE_W +: BYTE_W] = words_flat[k*CFG_W +: BYTE_W];
  end

  logic              coef_we_d, rnd_we_d, lim_we_d;
  logic              coef_ld, reg_ld;
  logic [COEF_W-1:0] coef_data_d;
  logic [REG_W-1:0]  reg_data_d;

  always_comb begin
    coef_we_d   = commit && (tgt == TGT_COEF);
    rnd_we_d    = commit && (tgt == TGT_RND);
    lim_we_d    = commit && (tgt == TGT_LIM);
    coef_ld     = coef_we_d;
    reg_ld      = rnd_we_d || lim_we_d;
    coef_data_d = words_flat;
    reg_data_d  = packed_bytes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_we <= 1'b0;
      rnd_we  <= 1'b0;
      lim_we  <= 1'b0;
    end else begin
      coef_we <= coef_we_d;
      rnd_we  <= rnd_we_d;
      lim_we  <= lim_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_row  <= '0;
      coef_data <= '0;
    end else if (coef_ld) begin
      coef_row  <= row;
      coef_data <= coef_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_idx  <= '0;
      reg_data <= '0;
    end else if (reg_ld) begin
      reg_idx  <= idx;
      reg_data <= reg_data_d;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({coef_we, rnd_we, lim_we})); // R11
  AST_COEF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> !coef_we); // R11
  AST_REG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_we || lim_we) |=> !(rnd_we || lim_we)); // R11
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tgt == TGT_NONE) |=> !(coef_we || rnd_we || lim_we)); // R9
  AST_REG_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rnd_we || lim_we) |-> $stable(reg_data) || $past(reg_ld)); // R5

endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cfg_loader_pkg::*;
#(
  parameter int CFG_W    = 12,
  parameter int NUM_DATA = 4,
  parameter int ROW_AW   = 8,
  parameter int IDX_W    = 4,
  parameter int BYTE_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_n,
  input  logic [CFG_W-1:0]            cfg_word,
  output logic                        coef_we,
  output logic [ROW_AW-1:0]           coef_row,
  output logic [NUM_DATA*CFG_W-1:0]   coef_data,
  output logic                        rnd_we,
  output logic                        lim_we,
  output logic [IDX_W-1:0]            reg_idx,
  output logic [NUM_DATA*BYTE_W-1:0]  reg_data
);

  logic                          take;
  logic                          last_now;
  logic [CFG_W-1:0]              addr_q;
  logic [(NUM_DATA-1)*CFG_W-1:0] slots_flat;
  logic [NUM_DATA*CFG_W-1:0]     words_all;
  tgt_e                          tgt;
  logic [ROW_AW-1:0]             row;
  logic [IDX_W-1:0]              idx;

  cfg_load_arm i_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .take   (take)
  );

  cfg_word_gather #(
    .CFG_W    (CFG_W),
    .NUM_DATA (NUM_DATA)
  ) i_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .word       (cfg_word),
    .addr_q     (addr_q),
    .slots_flat (slots_flat),
    .last_now   (last_now)
  );

  cfg_addr_decode #(
    .CFG_W  (CFG_W),
    .ROW_AW (ROW_AW),
    .IDX_W  (IDX_W)
  ) i_decode (
    .addr (addr_q),
    .tgt  (tgt),
    .row  (row),
    .idx  (idx)
  );

  assign words_all = {cfg_word, slots_flat};

  cfg_commit #(
    .CFG_W    (CFG_W),
    .NUM_DATA (NUM_DATA),
    .ROW_AW   (ROW_AW),
    .IDX_W    (IDX_W),
    .BYTE_W   (BYTE_W)
  ) i_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (last_now),
    .tgt        (tgt),
    .row        (row),
    .idx        (idx),
    .words_flat (words_all),
    .coef_we    (coef_we),
    .coef_row   (coef_row),
    .coef_data  (coef_data),
    .rnd_we     (rnd_we),
    .lim_we     (lim_we),
    .reg_idx    (reg_idx),
    .reg_data   (reg_data)
  );

  AST_WRITE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_we || rnd_we || lim_we) |-> !$past(load_n)); // R1

endmodule

// File: tb/test_cfg_word_loader.sv
module test_cfg_word_loader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_n;
  logic [11:0] cfg_word;
  logic        coef_we;
  logic [7:0]  coef_row;
  logic [47:0] coef_data;
  logic        rnd_we;
  logic        lim_we;
  logic [3:0]  reg_idx;
  logic [31:0] reg_data;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_word_loader i_cfg_word_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .cfg_word  (cfg_word),
    .coef_we   (coef_we),
    .coef_row  (coef_row),
    .coef_data (coef_data),
    .rnd_we    (rnd_we),
    .lim_we    (lim_we),
    .reg_idx   (reg_idx),
    .reg_data  (reg_data)
  );

  always @(negedge clk) if (rst_n && (coef_we || rnd_we || lim_we)) pulses++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [11:0] w);
    cfg_word = w;
    @(negedge clk);
  endtask

  task automatic send_group(input logic [11:0] a, input logic [11:0] w0,
                            input logic [11:0] w1, input logic [11:0] w2,
                            input logic [11:0] w3);
    send_word(a);
    send_word(w0);
    send_word(w1);
    send_word(w2);
    send_word(w3);
  endtask

  function automatic logic [11:0] dword(input int a, input int k);
    return 12'((a * 13 + k * 'h155 + 'h2A7) & 'hFFF);
  endfunction

  // compare the outputs present right after a group's last data word
  task automatic check_group(input int a, input logic [11:0] w0, input logic [11:0] w1,
                             input logic [11:0] w2, input logic [11:0] w3);
    logic [2:0] exp_we;
    logic [2:0] act_we;
    act_we = {coef_we, rnd_we, lim_we};
    if (a < 256) begin
      exp_we = 3'b100;
      exp_pulses++;
      chk(act_we == exp_we && coef_row == 8'(a) && coef_data == {w3, w2, w1, w0},
          "R4", "coef write", {8'(a), 4'(0), act_we, coef_data[47:0]},
          {8'(a), 4'(0), exp_we, w3, w2, w1, w0});
    end else if ((a >> 4) == 'h80) begin
      exp_we = 3'b010;
      exp_pulses++;
      chk(act_we == exp_we && reg_idx == 4'(a) && reg_data == {w3[7:0], w2[7:0], w1[7:0], w0[7:0]},
          "R5 R7", "round write", {act_we, reg_idx, reg_data},
          {exp_we, 4'(a), w3[7:0], w2[7:0], w1[7:0], w0[7:0]});
    end else if ((a >> 4) == 'hC0) begin
      exp_we = 3'b001;
      exp_pulses++;
      chk(act_we == exp_we && reg_idx == 4'(a) && reg_data == {w3[7:0], w2[7:0], w1[7:0], w0[7:0]},
          "R6 R7", "limit write", {act_we, reg_idx, reg_data},
          {exp_we, 4'(a), w3[7:0], w2[7:0], w1[7:0], w0[7:0]});
    end else begin
      exp_we = 3'b000;
      chk(act_we == exp_we, "R9", "invalid address wrote", 64'(act_we), 64'(exp_we));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    load_n   = 1'b0;
    cfg_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk({coef_we, rnd_we, lim_we} == 3'b000 && coef_row == 0 && coef_data == 0 &&
        reg_idx == 0 && reg_data == 0, "R11", "reset state",
        {coef_we, rnd_we, lim_we, coef_row, reg_idx}, 64'h0);

    // R2: strobe low from reset must not load
    send_group(12'h005, 12'h111, 12'h222, 12'h333, 12'h444);
    chk(!(coef_we || rnd_we || lim_we), "R2", "load without falling edge",
        {coef_we, rnd_we, lim_we}, 64'h0);
    send_group(12'h801, 12'h011, 12'h022, 12'h033, 12'h044);
    chk(pulses == 0, "R2", "pulses before arming", 64'(pulses), 64'h0);

    // arm with a high-to-low transition
    load_n = 1'b1;
    @(negedge clk);
    load_n = 1'b0;

    // R4 / R3: worked coefficient example
    send_group(12'd10, 12'hABC, 12'h789, 12'h456, 12'h123);
    check_group(10, 12'hABC, 12'h789, 12'h456, 12'h123);
    // R3: one cycle later the strobe is gone
    send_word(12'hFFF);
    chk(!coef_we, "R3", "strobe lasts one cycle", 64'(coef_we), 64'h0);
    send_word(12'h000);
    send_word(12'h000);
    send_word(12'h000);
    send_word(12'h000);
    check_group('hFFF, 0, 0, 0, 0);

    // R7: reserved bits set in round data
    send_group(12'h80A, 12'hF10, 12'hA32, 12'h554, 12'h376);
    chk(rnd_we && reg_idx == 4'hA && reg_data == 32'h7654_3210, "R7", "reserved bits ignored",
        {rnd_we, reg_idx, reg_data}, {1'b1, 4'hA, 32'h7654_3210});

    // R6: limit bounds
    send_group(12'hC0F, 12'h023, 12'h001, 12'h0ED, 12'h07F);
    chk(lim_we && reg_idx == 4'hF && reg_data[15:0] == 16'h0123 && reg_data[31:16] == 16'h7FED,
        "R6", "limit bounds", {lim_we, reg_idx, reg_data}, {1'b1, 4'hF, 16'h7FED, 16'h0123});
    exp_pulses += 2;

    // R10: abandon part way through a group
    send_word(12'h803);
    send_word(12'h011);
    send_word(12'h022);
    load_n = 1'b1;
    @(negedge clk);
    chk(!(coef_we || rnd_we || lim_we), "R10", "abandoned group wrote",
        {coef_we, rnd_we, lim_we}, 64'h0);
    load_n = 1'b0;
    send_group(12'h803, 12'h044, 12'h055, 12'h066, 12'h077);
    chk(rnd_we && reg_idx == 4'h3 && reg_data == 32'h7766_5544, "R10", "restart with address",
        {rnd_we, reg_idx, reg_data}, {1'b1, 4'h3, 32'h7766_5544});
    exp_pulses++;

    // R1: words while strobe high are ignored
    load_n = 1'b1;
    send_group(12'h007, 12'h001, 12'h002, 12'h003, 12'h004);
    send_word(12'h000);
    chk(pulses == exp_pulses, "R1", "writes while strobe high", 64'(pulses), 64'(exp_pulses));
    load_n = 1'b0;

    // R8 / R4 / R5 / R6 / R9: every address, groups back to back
    for (int a = 0; a < 4096; a++) begin
      send_group(12'(a), dword(a, 0), dword(a, 1), dword(a, 2), dword(a, 3));
      check_group(a, dword(a, 0), dword(a, 1), dword(a, 2), dword(a, 3));
    end
    load_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 / R9 / R11: total number of write pulses
    chk(pulses == exp_pulses, "R8", "total write pulses", 64'(pulses), 64'(exp_pulses));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule